// File: doc/BRIEF.md
# Trigger Line Output Selector

This block drives two active-low trigger output lines of a digitizer from a single 8-bit control register. Each line has its own 2-bit source field. The field selects one of three sources: a fixed-width low pulse for every converter start, a registered copy of the already-selected reference clock, or a constant high level. The constant high level releases the line so that it can serve as an input. The register also exports an active-high arm enable, derived from an active-low bit, and a 3-bit reference oscillator selection that other logic consumes.

The register is written through a one-cycle write strobe and always reads back its full 8-bit contents. The block runs on an 80 MHz clock, so a 25 ns trigger pulse lasts two clock cycles. A convert start that arrives while a pulse is still low restarts the two-cycle count.

Top module: `trig_out_select`

## Requirements
- R1: After a synchronous reset the register reads 0x78, `arm1_en` is 1, `ref_osc_sel` is 0, both `trig_line` bits are 1 and both `trig_oe` bits are 0.
- R2: When `wr_en` is high at a clock edge, `rd_data` shows `wr_data` from the next cycle on, with all 8 bits unchanged, including the reserved source code 10. Without `wr_en` the register holds its value.
- R3: `arm1_en` is the inverse of register bit 7: a bit value of 0 enables the arm source and a value of 1 blocks it.
- R4: `ref_osc_sel` equals register bits 2:0.
- R5: Line 1 takes its source code from register bits 6:5 and line 0 from bits 4:3. The codes are 00 = convert pulse, 01 = reference clock, 10 = reserved, 11 = released. The two lines act independently.
- R6: With code 00, a `conv_start` sampled high at an edge drives the line low for exactly PULSE_CYC cycles (2 by default) starting after that edge. Otherwise the line is high.
- R7: With code 00, a `conv_start` that arrives while the pulse is still low restarts the full PULSE_CYC count.
- R8: With code 01, the line equals `ref_clk_sel` as it was sampled at the previous clock edge.
- R9: With code 11, the line is high and its `trig_oe` bit is 0.
- R10: With the reserved code 10, the line is high and never goes low, even on `conv_start`, and its `trig_oe` bit is 1.
- R11: `trig_oe` is 1 for codes 00, 01 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 80 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register contents |
| conv_start | input | 1 | One-cycle converter start event |
| ref_clk_sel | input | 1 | Selected reference oscillator |
| arm1_en | output | 1 | Arm source enable, active high |
| ref_osc_sel | output | 3 | Reference oscillator selection field |
| trig_line | output | 2 | Trigger line levels, active low; bit i is line i |
| trig_oe | output | 2 | Per-line drive enable |

## Verification
On every cycle, the assertions check the relations that stay fixed over time. These are the write and hold behaviour of the register, the low level that follows a convert start, the return to high after two quiet cycles, reference clock tracking, the arm polarity, and the high level on released and reserved lines. Some behaviours show only in the bench's scenarios. These are the exact pulse width and the restart, the reset contents, and the independence of the two lines when their codes differ. The bench also sweeps all 256 register values and checks the decoded outputs for each one.

// File: rtl/trig_sel_pkg.sv
package trig_sel_pkg;

    localparam int REG_W     = 8;
    localparam int NUM_LINES = 2;
    localparam int SEL_W     = 3;

    typedef enum logic [1:0] {
        SRC_CONV_PULSE = 2'b00,
        SRC_REF_CLK    = 2'b01,
        SRC_RESERVED   = 2'b10,
        SRC_RELEASE    = 2'b11
    } trig_src_e;

    // Bit layout is fixed: neighbours decode these fields.
    typedef struct packed {
        logic             arm_block;   // bit 7, active-low enable
        trig_src_e        src_line1;   // bits 6:5
        trig_src_e        src_line0;   // bits 4:3
        logic [SEL_W-1:0] osc_sel;     // bits 2:0
    } trig_ctrl_t;

    localparam trig_ctrl_t CTRL_RESET = '{
        arm_block: 1'b0,
        src_line1: SRC_RELEASE,
        src_line0: SRC_RELEASE,
        osc_sel:   '0
    };

    function automatic logic line_level(trig_src_e src, logic pulse_on, logic ref_q);
        logic lvl;
        case (src)
            SRC_CONV_PULSE: lvl = ~pulse_on;
            SRC_REF_CLK:    lvl = ref_q;
            default:        lvl = 1'b1;
        endcase
        return lvl;
    endfunction

    function automatic logic line_drives(trig_src_e src);
        return src != SRC_RELEASE;
    endfunction

    function automatic trig_src_e line_src(trig_ctrl_t c, int idx);
        return (idx == 0) ? c.src_line0 : c.src_line1;
    endfunction

endpackage

// File: rtl/trig_ctrl_reg.sv
module trig_ctrl_reg
    import trig_sel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output trig_ctrl_t       ctrl
);

    trig_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RESET;
        else if (wr_en)
            ctrl_q <= trig_ctrl_t'(wr_data);
    end

    assign ctrl = ctrl_q;

    AST_WR_READBACK: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (REG_W'(ctrl_q) == $past(wr_data))); // R2
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q)); // R2

endmodule

// File: rtl/trig_pulse_stretch.sv
module trig_pulse_stretch #(
    parameter int PULSE_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active
);

    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (fire)
            cnt_q <= CNT_LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (rst)
        fire |=> active); // R6
    AST_PULSE_RESTART: assert property (@(posedge clk) disable iff (rst)
        fire |=> (cnt_q == CNT_LOAD)); // R7

endmodule

// File: rtl/trig_line_mux.sv
module trig_line_mux
    import trig_sel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  trig_src_e src,
    input  logic      pulse_on,
    input  logic      ref_in,
    output logic      line,
    output logic      oe
);

    logic ref_q;

    always_ff @(posedge clk) begin
        ref_q <= ref_in;
    end

    assign line = line_level(src, pulse_on, ref_q);
    assign oe   = line_drives(src);

    AST_REF_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_REF_CLK) |-> (line == $past(ref_in))); // R8

endmodule

// File: rtl/trig_out_select.sv
module trig_out_select
    import trig_sel_pkg::*;
#(
    parameter int PULSE_CYC = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [7:0]           wr_data,
    output logic [7:0]           rd_data,
    input  logic                 conv_start,
    input  logic                 ref_clk_sel,
    output logic                 arm1_en,
    output logic [2:0]           ref_osc_sel,
    output logic [1:0]           trig_line,
    output logic [1:0]           trig_oe
);

    trig_ctrl_t ctrl;

    trig_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    assign rd_data     = REG_W'(ctrl);
    assign arm1_en     = ~ctrl.arm_block;
    assign ref_osc_sel = ctrl.osc_sel;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic      pulse_on;
        trig_src_e src;

        assign src = line_src(ctrl, i);

        trig_pulse_stretch #(.PULSE_CYC(PULSE_CYC)) u_stretch (
            .clk    (clk),
            .rst    (rst),
            .fire   (conv_start),
            .active (pulse_on)
        );

        trig_line_mux u_mux (
            .clk      (clk),
            .rst      (rst),
            .src      (src),
            .pulse_on (pulse_on),
            .ref_in   (ref_clk_sel),
            .line     (trig_line[i]),
            .oe       (trig_oe[i])
        );

        AST_PULSE_LOW: assert property (@(posedge clk) disable iff (rst)
            ($past(conv_start) && rd_data[4+2*i -: 2] == 2'b00) |-> !trig_line[i]); // R6
        AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (rst)
            (!$past(conv_start) && !$past(conv_start, 2) && rd_data[4+2*i -: 2] == 2'b00)
            |-> trig_line[i]); // R6
        AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (rst)
            (rd_data[4+2*i -: 2] == 2'b11) |-> (trig_line[i] && !trig_oe[i])); // R9
        AST_RESERVED_HIGH: assert property (@(posedge clk) disable iff (rst)
            (rd_data[4+2*i -: 2] == 2'b10) |-> (trig_line[i] && trig_oe[i])); // R10
    end

    AST_ARM_POLARITY: assert property (@(posedge clk) disable iff (rst)
        arm1_en == !rd_data[7]); // R3

endmodule

// File: tb/test_trig_out_select.sv
module test_trig_out_select;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       conv_start = 1'b0;
    logic       ref_clk_sel = 1'b0;
    logic       arm1_en;
    logic [2:0] ref_osc_sel;
    logic [1:0] trig_line;
    logic [1:0] trig_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_out_select i_trig_out_select (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .conv_start  (conv_start),
        .ref_clk_sel (ref_clk_sel),
        .arm1_en     (arm1_en),
        .ref_osc_sel (ref_osc_sel),
        .trig_line   (trig_line),
        .trig_oe     (trig_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_reg(input logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    task automatic chk_lines(input logic [1:0] exp, input string req);
        chk(trig_line == exp, req, trig_line, exp);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1: reset contents
        chk(rd_data == 8'h78, "R1 rd_data", rd_data, 8'h78);
        chk(arm1_en == 1'b1, "R1 arm1_en", arm1_en, 1);
        chk(ref_osc_sel == 3'd0, "R1 ref_osc_sel", ref_osc_sel, 0);
        chk(trig_line == 2'b11, "R1 trig_line", trig_line, 3);
        chk(trig_oe == 2'b00, "R1 trig_oe", trig_oe, 0);

        // Sweep every register value: R2 R3 R4 R5 R8 R9 R10 R11
        for (int v = 0; v < 256; v++) begin
            logic [7:0] val;
            logic [1:0] exp_line1;
            logic [1:0] exp_line0;
            logic [1:0] exp_oe;
            val = 8'(v);
            ref_clk_sel = 1'b1;
            write_reg(val);
            chk(rd_data == val, "R2 readback", rd_data, val);
            chk(arm1_en == ~val[7], "R3 arm polarity", arm1_en, ~val[7]);
            chk(ref_osc_sel == val[2:0], "R4 osc select", ref_osc_sel, val[2:0]);
            for (int ln = 0; ln < 2; ln++) begin
                int code;
                code = (ln == 0) ? int'(val[4:3]) : int'(val[6:5]);
                exp_oe[ln] = (code != 3);
                exp_line0[ln] = 1'b1;
                exp_line1[ln] = (code == 1) ? 1'b0 : 1'b1;
            end
            chk(trig_oe == exp_oe, "R11 R9 oe per code", trig_oe, exp_oe);
            chk_lines(exp_line0, "R5 R8 idle level ref high");
            ref_clk_sel = 1'b0;
            step();
            chk_lines(exp_line1, "R8 line follows ref low");
            chk(rd_data == val, "R2 hold without write", rd_data, val);
        end

        // R6: single pulse on both lines, code 00
        ref_clk_sel = 1'b0;
        write_reg(8'h00);
        chk_lines(2'b11, "R6 idle before pulse");
        conv_start = 1'b1;
        step();
        conv_start = 1'b0;
        chk_lines(2'b00, "R6 pulse cycle 1");
        step();
        chk_lines(2'b00, "R6 pulse cycle 2");
        step();
        chk_lines(2'b11, "R6 pulse ended");
        step();
        chk_lines(2'b11, "R6 stays high");

        // R7: retrigger during the pulse
        conv_start = 1'b1;
        step();
        conv_start = 1'b0;
        chk_lines(2'b00, "R7 first low");
        step();
        conv_start = 1'b1;
        chk_lines(2'b00, "R7 second low");
        step();
        conv_start = 1'b0;
        chk_lines(2'b00, "R7 restarted low 1");
        step();
        chk_lines(2'b00, "R7 restarted low 2");
        step();
        chk_lines(2'b11, "R7 restarted pulse ended");

        // R5: line1 ref clock, line0 convert pulse (0x20)
        write_reg(8'h20);
        ref_clk_sel = 1'b1;
        step();
        chk_lines(2'b11, "R5 line1 ref high, line0 idle");
        conv_start = 1'b1;
        step();
        conv_start = 1'b0;
        chk_lines(2'b10, "R5 line0 pulse, line1 ref");
        ref_clk_sel = 1'b0;
        step();
        chk_lines(2'b00, "R5 line0 pulse, line1 ref low");
        step();
        chk_lines(2'b01, "R5 line0 back high, line1 ref low");

        // R5 R9: line1 pulse, line0 released (0x18)
        write_reg(8'h18);
        conv_start = 1'b1;
        step();
        conv_start = 1'b0;
        chk_lines(2'b01, "R5 R9 line1 pulse, line0 released");
        chk(trig_oe == 2'b10, "R9 line0 oe off", trig_oe, 2);

        // R10: reserved code on both lines never goes low (0x50)
        write_reg(8'h50);
        step();
        conv_start = 1'b1;
        step();
        conv_start = 1'b0;
        chk_lines(2'b11, "R10 reserved ignores convert");
        chk(trig_oe == 2'b11, "R10 reserved oe on", trig_oe, 3);
        step();
        chk_lines(2'b11, "R10 reserved still high");
        chk(rd_data == 8'h50, "R2 reserved codes readback", rd_data, 8'h50);

        // R1: reset again restores defaults
        rst = 1'b1;
        step();
        rst = 1'b0;
        step();
        chk(rd_data == 8'h78, "R1 second reset", rd_data, 8'h78);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule